// File: doc/BRIEF.md
# Demand-Stream Shadow Tag Directory

This block is a small set-associative directory of partial tags that follows the demand fetch stream of an instruction cache. It keeps no data, only a valid bit, a partial tag and a replacement age for each way. It is deliberately smaller than the cache it shadows. Each demand access looks up its set. A hit refreshes the recency order of that set. A miss allocates a way and, one cycle later, emits a single-cycle prefetch-trigger pulse that carries the missed line address. Prefetch traffic is never presented to it.

The set index comes from the lowest `IDX_W` bits of the line address, which carries no byte offset. The partial tag comes from the `TAG_W` bits just above the index. Any higher bits take no part in the lookup. Each set holds `WAYS` ways, three by default, with least-recently-used replacement. The order is kept as a per-way age: the accessed way takes age 0, and every way that was younger than it ages by one.

An outcome state machine holds the result of the last clock. Its states are `OUT_IDLE` (no access), `OUT_HIT` and `OUT_MISS`. From any state, the next state is `OUT_MISS` when a valid access misses, `OUT_HIT` when a valid access hits, and `OUT_IDLE` when no access is valid. The trigger output is high only in `OUT_MISS`.

Top module: `shadow_tag_monitor`

## Requirements
- R1: A synchronous reset (`rst` high) clears every valid bit and returns the outcome state to `OUT_IDLE`. After reset `pf_trig` is 0, and the first access to any address misses.
- R2: When an access (`dmd_valid`=1) misses, `pf_trig` is 1 in the cycle after it, and `pf_line` equals the accessed `dmd_line`.
- R3: When an access hits, `pf_trig` is 0 in the following cycle. A trigger pulse lasts exactly one cycle unless the next access also misses.
- R4: The index is `dmd_line[IDX_W-1:0]` and the partial tag is `dmd_line[IDX_W+TAG_W-1:IDX_W]`. Two addresses that differ only above these bits are treated as the same line, so the second one hits.
- R5: A set holds `WAYS` distinct tags at once. After `WAYS` different tags are filled into one set, all of them hit, and at most one way matches any lookup.
- R6: Replacement is least-recently-used. A miss in a full set evicts the way whose last access (hit or fill) is the oldest. The ages of the ways in a set always form a permutation of 0..`WAYS`-1.
- R7: Sets are independent. Accesses to one set never evict lines in another set.
- R8: While `dmd_valid` is 0 the directory is unchanged, and `pf_trig` is 0 in the following cycle.
- R9: Back-to-back accesses each see the state left by the access before them. The same new address presented on two consecutive cycles misses first and then hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dmd_valid | input | 1 | A demand access is present this cycle |
| dmd_line | input | LADDR_W | Line address of the demand access (no byte offset) |
| pf_trig | output | 1 | Registered one-cycle prefetch trigger on a miss |
| pf_line | output | LADDR_W | Line address that missed, valid while `pf_trig` is high |

## Verification
Every result is due exactly one clock after the access that causes it. The lookup and the allocation both happen at the edge that accepts the access, and the outcome register shows the trigger right after that edge. The bench drives each access on a falling edge and samples `pf_trig` and `pf_line` on the next falling edge, so the one registered stage falls between the two. Back-to-back accesses are driven on consecutive falling edges, so each sample also tests that the state written by the previous edge is seen. Idle and reset checks are sampled one falling edge after the quiet or reset cycle.

// File: rtl/shc_pkg.sv
package shc_pkg;

    typedef enum logic [1:0] {
        OUT_IDLE = 2'd0,
        OUT_HIT  = 2'd1,
        OUT_MISS = 2'd2
    } outcome_e;

    function automatic int age_width(input int ways);
        return (ways > 1) ? $clog2(ways) : 1;
    endfunction

endpackage

// File: rtl/shc_way_store.sv
module shc_way_store #(
    parameter int IDX_W = 5,
    parameter int TAG_W = 15,
    parameter int WAYS  = 3,
    parameter int AGE_W = 2
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [IDX_W-1:0]                 set_idx,
    input  logic                             upd_en,
    input  logic [WAYS-1:0]                  fill_vec,
    input  logic [TAG_W-1:0]                 fill_tag,
    input  logic [WAYS-1:0][AGE_W-1:0]       new_age,
    output logic [WAYS-1:0]                  rd_valid,
    output logic [WAYS-1:0][TAG_W-1:0]       rd_tag,
    output logic [WAYS-1:0][AGE_W-1:0]       rd_age
);

    localparam int SETS = 1 << IDX_W;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [SETS-1:0]  vld_q;
        logic [TAG_W-1:0] tag_mem [SETS];
        logic [AGE_W-1:0] age_mem [SETS];

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q <= '0;
                for (int s = 0; s < SETS; s++) begin
                    age_mem[s] <= AGE_W'(w);
                end
            end else if (upd_en) begin
                age_mem[set_idx] <= new_age[w];
                if (fill_vec[w]) begin
                    vld_q[set_idx] <= 1'b1;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (upd_en && fill_vec[w] && !rst) begin
                tag_mem[set_idx] <= fill_tag;
            end
        end

        assign rd_valid[w] = vld_q[set_idx];
        assign rd_tag[w]   = tag_mem[set_idx];
        assign rd_age[w]   = age_mem[set_idx];
    end

endmodule

// File: rtl/shc_set_lookup.sv
module shc_set_lookup #(
    parameter int TAG_W = 15,
    parameter int WAYS  = 3,
    parameter int AGE_W = 2
) (
    input  logic [WAYS-1:0]            rd_valid,
    input  logic [WAYS-1:0][TAG_W-1:0] rd_tag,
    input  logic [WAYS-1:0][AGE_W-1:0] rd_age,
    input  logic [TAG_W-1:0]           cmp_tag,
    output logic [WAYS-1:0]            hit_vec,
    output logic                       hit_any,
    output logic [WAYS-1:0]            victim_vec,
    output logic [WAYS-1:0]            sel_vec
);

    localparam logic [AGE_W-1:0] OLDEST = AGE_W'(WAYS - 1);

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = rd_valid[w] && (rd_tag[w] == cmp_tag);
    end

    assign hit_any = |hit_vec;

    always_comb begin
        logic found;
        victim_vec = '0;
        found      = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !rd_valid[w]) begin
                victim_vec[w] = 1'b1;
                found         = 1'b1;
            end
        end
        if (!found) begin
            for (int w = 0; w < WAYS; w++) begin
                if (rd_age[w] == OLDEST) begin
                    victim_vec[w] = 1'b1;
                end
            end
        end
    end

    assign sel_vec = hit_any ? hit_vec : victim_vec;

endmodule

// File: rtl/shc_age_update.sv
module shc_age_update #(
    parameter int WAYS  = 3,
    parameter int AGE_W = 2
) (
    input  logic [WAYS-1:0][AGE_W-1:0] cur_age,
    input  logic [WAYS-1:0]            sel_vec,
    output logic [WAYS-1:0][AGE_W-1:0] new_age
);

    logic [AGE_W-1:0] sel_age;

    always_comb begin
        sel_age = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (sel_vec[w]) begin
                sel_age = sel_age | cur_age[w];
            end
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_age
        always_comb begin
            if (sel_vec[w]) begin
                new_age[w] = '0;
            end else if (cur_age[w] < sel_age) begin
                new_age[w] = cur_age[w] + AGE_W'(1);
            end else begin
                new_age[w] = cur_age[w];
            end
        end
    end

endmodule

// File: rtl/shadow_tag_monitor.sv
module shadow_tag_monitor
    import shc_pkg::*;
#(
    parameter int LADDR_W = 26,
    parameter int IDX_W   = 5,
    parameter int TAG_W   = 15,
    parameter int WAYS    = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               dmd_valid,
    input  logic [LADDR_W-1:0] dmd_line,
    output logic               pf_trig,
    output logic [LADDR_W-1:0] pf_line
);

    localparam int AGE_W = age_width(WAYS);

    logic [IDX_W-1:0]            set_idx;
    logic [TAG_W-1:0]            lk_tag;
    logic [WAYS-1:0]             rd_valid;
    logic [WAYS-1:0][TAG_W-1:0]  rd_tag;
    logic [WAYS-1:0][AGE_W-1:0]  rd_age;
    logic [WAYS-1:0][AGE_W-1:0]  new_age;
    logic [WAYS-1:0]             hit_vec;
    logic [WAYS-1:0]             victim_vec;
    logic [WAYS-1:0]             sel_vec;
    logic [WAYS-1:0]             fill_vec;
    logic                        hit_any;
    outcome_e                    state_q;
    outcome_e                    state_d;
    logic [LADDR_W-1:0]          line_q;

    assign set_idx  = dmd_line[IDX_W-1:0];
    assign lk_tag   = dmd_line[IDX_W+TAG_W-1:IDX_W];
    assign fill_vec = hit_any ? '0 : victim_vec;

    shc_way_store #(
        .IDX_W (IDX_W),
        .TAG_W (TAG_W),
        .WAYS  (WAYS),
        .AGE_W (AGE_W)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .set_idx  (set_idx),
        .upd_en   (dmd_valid),
        .fill_vec (fill_vec),
        .fill_tag (lk_tag),
        .new_age  (new_age),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .rd_age   (rd_age)
    );

    shc_set_lookup #(
        .TAG_W (TAG_W),
        .WAYS  (WAYS),
        .AGE_W (AGE_W)
    ) u_lookup (
        .rd_valid   (rd_valid),
        .rd_tag     (rd_tag),
        .rd_age     (rd_age),
        .cmp_tag    (lk_tag),
        .hit_vec    (hit_vec),
        .hit_any    (hit_any),
        .victim_vec (victim_vec),
        .sel_vec    (sel_vec)
    );

    shc_age_update #(
        .WAYS  (WAYS),
        .AGE_W (AGE_W)
    ) u_age (
        .cur_age (rd_age),
        .sel_vec (sel_vec),
        .new_age (new_age)
    );

    // Next outcome: the transition depends only on this cycle's access.
    always_comb begin
        unique case ({dmd_valid, hit_any})
            2'b11:   state_d = OUT_HIT;
            2'b10:   state_d = OUT_MISS;
            default: state_d = OUT_IDLE;
        endcase
    end

    // State register together with the captured line address.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= OUT_IDLE;
            line_q  <= '0;
        end else begin
            state_q <= state_d;
            if (dmd_valid) begin
                line_q <= dmd_line;
            end
        end
    end

    // Outputs decoded from the registered outcome.
    always_comb begin
        unique case (state_q)
            OUT_MISS: pf_trig = 1'b1;
            OUT_HIT:  pf_trig = 1'b0;
            default:  pf_trig = 1'b0;
        endcase
        pf_line = line_q;
    end

endmodule

// File: rtl/shc_checker.sv
module shc_checker #(
    parameter int LADDR_W = 26,
    parameter int WAYS    = 3,
    parameter int AGE_W   = 2
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       dmd_valid,
    input logic [LADDR_W-1:0]         dmd_line,
    input logic                       pf_trig,
    input logic [LADDR_W-1:0]         pf_line,
    input logic [WAYS-1:0]            hit_vec,
    input logic                       hit_any,
    input logic [WAYS-1:0][AGE_W-1:0] age_vec
);

    // R2
    miss_trig_chk: assert property (@(posedge clk) disable iff (rst)
        (dmd_valid && !hit_any) |=> (pf_trig && pf_line == $past(dmd_line)));

    // R3
    hit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (dmd_valid && hit_any) |=> !pf_trig);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !dmd_valid |=> !pf_trig);

    // R5
    single_match_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    for (genvar i = 0; i < WAYS; i++) begin : g_rng
        // R6
        age_range_chk: assert property (@(posedge clk) disable iff (rst)
            age_vec[i] <= AGE_W'(WAYS - 1));
        for (genvar j = i + 1; j < WAYS; j++) begin : g_pair
            // R6
            age_distinct_chk: assert property (@(posedge clk) disable iff (rst)
                age_vec[i] != age_vec[j]);
        end
    end

endmodule

bind shadow_tag_monitor shc_checker #(
    .LADDR_W (LADDR_W),
    .WAYS    (WAYS),
    .AGE_W   (AGE_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .dmd_valid (dmd_valid),
    .dmd_line  (dmd_line),
    .pf_trig   (pf_trig),
    .pf_line   (pf_line),
    .hit_vec   (hit_vec),
    .hit_any   (hit_any),
    .age_vec   (rd_age)
);

// File: tb/sim_shadow_tag_monitor.sv
module sim_shadow_tag_monitor;

    localparam int LADDR_W = 18;
    localparam int IDX_W   = 2;
    localparam int TAG_W   = 15;
    localparam int WAYS    = 3;
    localparam int SETS    = 1 << IDX_W;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               dmd_valid = 1'b0;
    logic [LADDR_W-1:0] dmd_line = '0;
    logic               pf_trig;
    logic [LADDR_W-1:0] pf_line;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // Recency-ordered model: position 0 is the most recently used.
    int mdl_tag [SETS][WAYS];
    int mdl_cnt [SETS];

    always #10 clk = ~clk;

    shadow_tag_monitor #(
        .LADDR_W (LADDR_W),
        .IDX_W   (IDX_W),
        .TAG_W   (TAG_W),
        .WAYS    (WAYS)
    ) u0 (
        .clk       (clk),
        .rst       (rst),
        .dmd_valid (dmd_valid),
        .dmd_line  (dmd_line),
        .pf_trig   (pf_trig),
        .pf_line   (pf_line)
    );

    function automatic logic [LADDR_W-1:0] mk(input int hi, input int tag, input int idx);
        return {hi[0], tag[TAG_W-1:0], idx[IDX_W-1:0]};
    endfunction

    function automatic bit mdl_access(input logic [LADDR_W-1:0] a);
        int s;
        int t;
        int pos;
        s   = int'(a[IDX_W-1:0]);
        t   = int'(a[IDX_W+TAG_W-1:IDX_W]);
        pos = -1;
        for (int p = 0; p < mdl_cnt[s]; p++) begin
            if (mdl_tag[s][p] == t) pos = p;
        end
        if (pos < 0) begin
            if (mdl_cnt[s] < WAYS) mdl_cnt[s]++;
            pos = mdl_cnt[s] - 1;
        end
        for (int p = pos; p > 0; p--) mdl_tag[s][p] = mdl_tag[s][p-1];
        mdl_tag[s][0] = t;
        return (pos == mdl_cnt[s] - 1) && !mdl_hit_before;
    endfunction

    bit mdl_hit_before;

    function automatic bit mdl_lookup(input logic [LADDR_W-1:0] a);
        int s;
        int t;
        s = int'(a[IDX_W-1:0]);
        t = int'(a[IDX_W+TAG_W-1:IDX_W]);
        for (int p = 0; p < mdl_cnt[s]; p++) begin
            if (mdl_tag[s][p] == t) return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic mdl_clear();
        for (int s = 0; s < SETS; s++) mdl_cnt[s] = 0;
    endtask

    // Drive one access at a falling edge; its result is due one edge later.
    task automatic acc(input logic [LADDR_W-1:0] a, input string req);
        bit exp_miss;
        exp_miss       = !mdl_lookup(a);
        mdl_hit_before = !exp_miss;
        void'(mdl_access(a));
        dmd_valid = 1'b1;
        dmd_line  = a;
        @(negedge clk);
        check(pf_trig == exp_miss, req, int'(pf_trig), int'(exp_miss));
        if (exp_miss) check(pf_line == a, req, int'(pf_line), int'(a));
    endtask

    task automatic idle(input int n, input string req);
        dmd_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(pf_trig == 1'b0, req, int'(pf_trig), 0);
        end
    endtask

    task automatic do_reset();
        dmd_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        mdl_clear();
        check(pf_trig == 1'b0, "R1", int'(pf_trig), 0);
    endtask

    initial begin
        logic [15:0] lfsr;
        mdl_clear();
        mdl_hit_before = 1'b0;
        @(negedge clk);
        do_reset();

        // R1 R2: cold misses in every set
        for (int s = 0; s < SETS; s++) acc(mk(0, 5, s), "R1");
        // R9: same new line twice in a row
        acc(mk(0, 9, 0), "R9");
        acc(mk(0, 9, 0), "R9");
        // R3: pulse is one cycle wide
        acc(mk(0, 33, 2), "R2");
        idle(1, "R3");
        acc(mk(0, 33, 2), "R3");
        // R5: set 1 holds three tags
        acc(mk(0, 100, 1), "R5");
        acc(mk(0, 101, 1), "R5");
        acc(mk(0, 100, 1), "R5");
        acc(mk(0, 101, 1), "R5");
        acc(mk(0, 5, 1), "R5");
        // R6: recency 5,101,100 -> 100 is the LRU; touch 100, then 200 evicts 101
        acc(mk(0, 100, 1), "R6");
        acc(mk(0, 200, 1), "R6");
        acc(mk(0, 101, 1), "R6");
        acc(mk(0, 100, 1), "R6");
        // R7: churn set 3, set 2 lines stay
        for (int t = 0; t < 6; t++) acc(mk(0, 300 + t, 3), "R7");
        acc(mk(0, 33, 2), "R7");
        acc(mk(0, 5, 2), "R7");
        // R4: upper bit ignored; same tag other index is separate
        acc(mk(1, 33, 2), "R4");
        acc(mk(0, 33, 0), "R4");
        // R8: idle cycles leave state untouched
        idle(4, "R8");
        acc(mk(0, 33, 2), "R8");

        // R6: sweep over a small line pool compared with the LRU model
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[3:0] == 4'd0) begin
                idle(1, "R8");
            end else begin
                acc(mk(int'(lfsr[15]), int'(lfsr[9:7]) % 5, int'(lfsr[1:0])), "R6");
            end
        end

        // R1: reset mid-stream empties the directory
        acc(mk(0, 33, 2), "R1");
        do_reset();
        acc(mk(0, 33, 2), "R1");
        idle(1, "R3");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule